// File: doc/BRIEF.md
# Dead-Time PWM Generator with Sub-Cycle Edge Taps

This block produces the complementary gate timing for one phase of a synchronous buck converter: a high-side pulse (`gh`) and a synchronous-switch pulse (`gl`). Each switching period lasts a programmable number of master-clock cycles. Every edge time inside the period is held in fine units of one sixteenth of a clock. The upper bits of that time pick the clock cycle in which the coarse output toggles. The low four bits are presented on tap-select outputs, which an external delay line uses to place the edge at sub-cycle resolution. This fine step applies to the high-side pulse width and to both dead times.

A control loop supplies an on-time command in fine units. The configuration supplies the period in clocks, plus the minimum on-time, maximum on-time and dead time in fine units. All of these are taken once, at the first cycle of each period, so a change in the middle of a period does not affect the pulse already in progress. The on-time is clamped to the programmed window. It is then cut so that both dead times and a final low-side interval fit inside the period.

A five-state machine sequences the period. The states are IDLE (both gates off), LEAD_DEAD (the gap before the high side turns on), HS_ON (high side on), TRAIL_DEAD (the gap after the high side turns off) and LS_ON (synchronous switch on). The transitions are:
- start: IDLE to LEAD_DEAD, when enable is seen.
- turn_on: LEAD_DEAD to HS_ON, at the rise count.
- turn_off: HS_ON to TRAIL_DEAD, at the fall count.
- ls_on: TRAIL_DEAD to LS_ON, at the low-side count.
- wrap: LS_ON to LEAD_DEAD, at the period end while enabled.
- stop: LS_ON or LEAD_DEAD to IDLE, at the period end while disabled.
- skip_wrap: LEAD_DEAD to LEAD_DEAD, for a period too short to fit any pulse.

Top module: `hr_deadtime_pwm`

## Requirements
- R1: After reset, `gh`, `gl` and all three tap outputs are 0. While `enable` stays low from reset, both gates stay low.
- R2: A period starts on the clock edge after `enable` is seen high in IDLE, or right after the previous period ends. `gl` is low in cycle 0 of a period. The period lasts max(`cfg_period`, 2) clocks, and periods follow back to back while enabled.
- R3: With dead time D and effective on-time T in fine units (16 per clock), `gh` is high in the cycles from floor(D/16) up to, but not including, floor((D+T)/16). `gl` is high from cycle floor((2D+T)/16) to the end of the period.
- R4: `gh_rise_tap`, `gh_fall_tap` and `gl_rise_tap` are the low 4 bits of D, D+T and 2D+T. They change only at the start of a period.
- R5: The command is raised to `cfg_min_on` when it is below it, and then cut to `cfg_max_on` when it is above it, so the maximum wins if the two conflict. The result is never below 16.
- R6: A dead time below 16 fine units is treated as 16.
- R7: T is cut to at most 16*P - 16 - 2D, where P is the effective period. If that limit is below 16, the period is skipped and both gates stay low for all of it.
- R8: `gh` and `gl` are never high together. After either gate falls, the other stays low for at least one clock.
- R9: Changes to the command or configuration in the middle of a period do not alter that period. They take effect from the next period.
- R10: If `enable` goes low during a period, that period completes as planned. Both gates then stay low, and the taps keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request, sampled at period boundaries |
| duty_cmd | input | 14 | Requested on-time in fine units |
| cfg_period | input | 10 | Switching period in clocks |
| cfg_min_on | input | 14 | Minimum on-time in fine units |
| cfg_max_on | input | 14 | Maximum on-time in fine units |
| cfg_dead | input | 14 | Dead time in fine units |
| gh | output | 1 | High-side gate timing |
| gl | output | 1 | Low-side gate timing |
| gh_rise_tap | output | 4 | Sub-cycle tap for the `gh` rising edge |
| gh_fall_tap | output | 4 | Sub-cycle tap for the `gh` falling edge |
| gl_rise_tap | output | 4 | Sub-cycle tap for the `gl` rising edge |

## Verification
The pulse sequence is exercised with several kinds of command:
- A command inside the clamp window, which shows that plain edge placement works.
- Commands below the minimum, above the maximum, and with crossed limits, which separate the three clamp branches.
- A dead time below the floor and an on-time that only just fits the period, which expose the floor and the fit limit.
- A period too short for any pulse, which must produce a skipped period rather than an overlap.

Odd fine values and a period near the top of the range check the split between the tap bits and the coarse cycle. Directed runs change the command in the middle of a period and drop `enable` in the middle of a period. These show whether values are taken only at the period start, and whether shutdown waits for the period boundary.

// File: rtl/hdpwm_pkg.sv
package hdpwm_pkg;

    typedef enum logic [2:0] {
        PS_IDLE  = 3'd0,
        PS_LEAD  = 3'd1,
        PS_HIGH  = 3'd2,
        PS_TRAIL = 3'd3,
        PS_LOW   = 3'd4
    } pwm_state_t;

endpackage

// File: rtl/hdpwm_clamp.sv
// Turns the raw command and configuration into coarse edge counts and fine taps.
module hdpwm_clamp #(
    parameter int CNT_W  = 10,
    parameter int FINE_W = 4
) (
    input  logic [CNT_W-1:0]        period,
    input  logic [CNT_W+FINE_W-1:0] duty,
    input  logic [CNT_W+FINE_W-1:0] min_on,
    input  logic [CNT_W+FINE_W-1:0] max_on,
    input  logic [CNT_W+FINE_W-1:0] dead,
    output logic [CNT_W-1:0]        plen,
    output logic [CNT_W-1:0]        c_rise,
    output logic [CNT_W-1:0]        c_fall,
    output logic [CNT_W-1:0]        c_glr,
    output logic [FINE_W-1:0]       t_rise,
    output logic [FINE_W-1:0]       t_fall,
    output logic [FINE_W-1:0]       t_glr,
    output logic                    skip
);
    localparam int TW = CNT_W + FINE_W;
    localparam int XW = TW + 3;
    localparam logic [XW-1:0] ONE = XW'(1) << FINE_W;

    logic [XW-1:0] span, d_x, two_d, on_c, fit, on_f, t_f, t_l;
    logic [TW-1:0] on_a, on_b;
    logic          unused_hi;

    always_comb begin
        plen  = (period < CNT_W'(2)) ? CNT_W'(2) : period;
        span  = XW'(plen) << FINE_W;
        d_x   = (XW'(dead) < ONE) ? ONE : XW'(dead);
        two_d = d_x << 1;
        // R5: minimum first, then maximum, then one-clock floor
        on_a  = (duty < min_on) ? min_on : duty;
        on_b  = (on_a > max_on) ? max_on : on_a;
        on_c  = (XW'(on_b) < ONE) ? ONE : XW'(on_b);
        // R7: leave both dead times and one low-side clock inside the period
        skip  = span < (ONE + ONE + two_d);
        fit   = span - ONE - two_d;
        if (skip)
            on_f = ONE;
        else if (on_c > fit)
            on_f = fit;
        else
            on_f = on_c;
        t_f    = d_x + on_f;
        t_l    = two_d + on_f;
        c_rise = d_x[FINE_W +: CNT_W];
        c_fall = t_f[FINE_W +: CNT_W];
        c_glr  = t_l[FINE_W +: CNT_W];
        t_rise = d_x[FINE_W-1:0];
        t_fall = t_f[FINE_W-1:0];
        t_glr  = t_l[FINE_W-1:0];
    end

    assign unused_hi = ^{d_x[XW-1:TW], t_f[XW-1:TW], t_l[XW-1:TW]};

endmodule

// File: rtl/hdpwm_counter.sv
// Cycle index within the current period.
module hdpwm_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/hdpwm_fsm.sv
// Period sequencer: latches the plan at period start and walks the five states.
module hdpwm_fsm
    import hdpwm_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int FINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  plen,
    input  logic [CNT_W-1:0]  c_rise,
    input  logic [CNT_W-1:0]  c_fall,
    input  logic [CNT_W-1:0]  c_glr,
    input  logic [FINE_W-1:0] t_rise,
    input  logic [FINE_W-1:0] t_fall,
    input  logic [FINE_W-1:0] t_glr,
    input  logic              skip,
    output logic              clear,
    output logic              gh,
    output logic              gl,
    output logic [FINE_W-1:0] tap_rise,
    output logic [FINE_W-1:0] tap_fall,
    output logic [FINE_W-1:0] tap_glr
);
    pwm_state_t       state, st_nxt;
    logic [CNT_W-1:0] plen_q, rise_q, fall_q, glr_q, cnt_inc;
    logic             skip_q, wrap, load;

    assign cnt_inc = cnt + CNT_W'(1);
    assign wrap    = (state != PS_IDLE) && (cnt == plen_q - CNT_W'(1));
    assign load    = wrap || ((state == PS_IDLE) && enable);
    assign clear   = (state == PS_IDLE) || wrap;

    // R9: plan captured only on the period-start edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            plen_q   <= CNT_W'(2);
            rise_q   <= '0;
            fall_q   <= '0;
            glr_q    <= '0;
            skip_q   <= 1'b1;
            tap_rise <= '0;
            tap_fall <= '0;
            tap_glr  <= '0;
        end else if (load && enable) begin
            plen_q   <= plen;
            rise_q   <= c_rise;
            fall_q   <= c_fall;
            glr_q    <= c_glr;
            skip_q   <= skip;
            tap_rise <= t_rise;
            tap_fall <= t_fall;
            tap_glr  <= t_glr;
        end
    end

    always_comb begin
        st_nxt = state;
        unique case (state)
            PS_IDLE: begin
                if (enable) st_nxt = PS_LEAD;
            end
            PS_LEAD: begin
                if (wrap)
                    st_nxt = enable ? PS_LEAD : PS_IDLE;
                else if (!skip_q && (cnt_inc == rise_q))
                    st_nxt = PS_HIGH;
            end
            PS_HIGH: begin
                if (cnt_inc == fall_q) st_nxt = PS_TRAIL;
            end
            PS_TRAIL: begin
                if (cnt_inc == glr_q) st_nxt = PS_LOW;
            end
            PS_LOW: begin
                if (wrap) st_nxt = enable ? PS_LEAD : PS_IDLE;
            end
            default: st_nxt = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= PS_IDLE;
        else
            state <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gh <= 1'b0;
            gl <= 1'b0;
        end else begin
            gh <= (st_nxt == PS_HIGH);
            gl <= (st_nxt == PS_LOW);
        end
    end

endmodule

// File: rtl/hr_deadtime_pwm.sv
module hr_deadtime_pwm #(
    parameter int CNT_W  = 10,
    parameter int FINE_W = 4,
    localparam int TIME_W = CNT_W + FINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [TIME_W-1:0] duty_cmd,
    input  logic [CNT_W-1:0]  cfg_period,
    input  logic [TIME_W-1:0] cfg_min_on,
    input  logic [TIME_W-1:0] cfg_max_on,
    input  logic [TIME_W-1:0] cfg_dead,
    output logic              gh,
    output logic              gl,
    output logic [FINE_W-1:0] gh_rise_tap,
    output logic [FINE_W-1:0] gh_fall_tap,
    output logic [FINE_W-1:0] gl_rise_tap
);
    logic [CNT_W-1:0]  plen, c_rise, c_fall, c_glr, cnt;
    logic [FINE_W-1:0] t_rise, t_fall, t_glr;
    logic              skip, clear;

    hdpwm_clamp #(.CNT_W(CNT_W), .FINE_W(FINE_W)) u_clamp (
        .period (cfg_period),
        .duty   (duty_cmd),
        .min_on (cfg_min_on),
        .max_on (cfg_max_on),
        .dead   (cfg_dead),
        .plen   (plen),
        .c_rise (c_rise),
        .c_fall (c_fall),
        .c_glr  (c_glr),
        .t_rise (t_rise),
        .t_fall (t_fall),
        .t_glr  (t_glr),
        .skip   (skip)
    );

    hdpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .cnt   (cnt)
    );

    hdpwm_fsm #(.CNT_W(CNT_W), .FINE_W(FINE_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .cnt      (cnt),
        .plen     (plen),
        .c_rise   (c_rise),
        .c_fall   (c_fall),
        .c_glr    (c_glr),
        .t_rise   (t_rise),
        .t_fall   (t_fall),
        .t_glr    (t_glr),
        .skip     (skip),
        .clear    (clear),
        .gh       (gh),
        .gl       (gl),
        .tap_rise (gh_rise_tap),
        .tap_fall (gh_fall_tap),
        .tap_glr  (gl_rise_tap)
    );

endmodule

// File: rtl/hdpwm_chk.sv
module hdpwm_chk #(
    parameter int FINE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gh,
    input logic              gl,
    input logic [FINE_W-1:0] gh_rise_tap,
    input logic [FINE_W-1:0] gh_fall_tap,
    input logic [FINE_W-1:0] gl_rise_tap
);
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(gh && gl));

    a_r8_gap_after_gh: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gh) |-> !gl);

    a_r8_gap_after_gl: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gl) |-> !gh);

    a_r3_lead_dead: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gh) |-> !$past(gl));

    a_r4_taps_hold: assert property (@(posedge clk) disable iff (!rst_n)
        gh |-> ($stable(gh_rise_tap) && $stable(gh_fall_tap) && $stable(gl_rise_tap)));
endmodule

bind hr_deadtime_pwm hdpwm_chk #(.FINE_W(FINE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gh          (gh),
    .gl          (gl),
    .gh_rise_tap (gh_rise_tap),
    .gh_fall_tap (gh_fall_tap),
    .gl_rise_tap (gl_rise_tap)
);

// File: tb/tb_hr_deadtime_pwm.sv
`timescale 1ns/1ps
module tb_hr_deadtime_pwm;
    localparam int CW = 10;
    localparam int FW = 4;
    localparam int TW = CW + FW;
    localparam int NV = 10;
    // period(clk), dead, min_on, max_on, duty (fine units)
    localparam int VEC [NV][5] = '{
        '{40, 40, 64, 400, 200},      // R3 plain
        '{40, 40, 100, 400, 30},      // R5 below min
        '{40, 40, 64, 300, 500},      // R5 above max
        '{32, 5, 16, 400, 120},       // R6 dead floor
        '{20, 48, 16, 400, 300},      // R7 fit limit
        '{4, 40, 16, 400, 100},       // R7 skip
        '{40, 40, 200, 100, 150},     // R5 max wins
        '{25, 16, 0, 800, 3},         // R5 one-clock floor
        '{33, 37, 20, 1000, 123},     // R4 odd fine values
        '{981, 350, 800, 12000, 5000} // R2 long period
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [TW-1:0] duty = '0, mn = '0, mx = '0, dd = '0;
    logic [CW-1:0] per = '0;
    logic gh, gl;
    logic [FW-1:0] trise, tfall, tglr;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int hk_k = -1, hk_duty = 0, hk_dead = 0, hk_en = 1;

    always #10 clk = ~clk;

    hr_deadtime_pwm dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .duty_cmd(duty),
        .cfg_period(per), .cfg_min_on(mn), .cfg_max_on(mx), .cfg_dead(dd),
        .gh(gh), .gl(gl), .gh_rise_tap(trise), .gh_fall_tap(tfall), .gl_rise_tap(tglr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic calc(input int p, input int d0, input int lo, input int hi, input int du,
                        output int rc, output int fc, output int lc, output int pl,
                        output int tr, output int tf, output int tl);
        int d, on, span, fit;
        pl = (p < 2) ? 2 : p;
        span = pl * 16;
        d = (d0 < 16) ? 16 : d0;
        on = (du < lo) ? lo : du;
        if (on > hi) on = hi;
        if (on < 16) on = 16;
        fit = span - 16 - 2 * d;
        if (fit < 16) begin
            rc = pl; fc = pl; lc = pl; tr = 0; tf = 0; tl = 0;
        end else begin
            if (on > fit) on = fit;
            rc = d / 16; fc = (d + on) / 16; lc = (2 * d + on) / 16;
            tr = d % 16; tf = (d + on) % 16; tl = (2 * d + on) % 16;
        end
    endtask

    // Samples one period, k = 0 .. pl-1, one sample per falling edge.
    task automatic observe(input int rc, input int fc, input int lc, input int pl, input string req);
        int bgh = 0, bgl = 0, bov = 0, k_gh = -1, k_gl = -1;
        for (int k = 0; k < pl; k++) begin
            @(negedge clk);
            if (gh !== ((k >= rc) && (k < fc))) begin bgh++; if (k_gh < 0) k_gh = k; end
            if (gl !== (k >= lc)) begin bgl++; if (k_gl < 0) k_gl = k; end
            if (gh && gl) bov++;
            if (k == hk_k) begin
                duty = TW'(hk_duty); dd = TW'(hk_dead); enable = (hk_en != 0);
            end
        end
        chk({req, " gh mismatching cycles (first at ", $sformatf("%0d", k_gh), ")"}, bgh, 0);
        chk({req, " gl mismatching cycles (first at ", $sformatf("%0d", k_gl), ")"}, bgl, 0);
        chk({req, " R8 overlap cycles"}, bov, 0);
    endtask

    task automatic start_run(input int p, input int d0, input int lo, input int hi, input int du);
        rst_n = 1'b0;
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        per = CW'(p); dd = TW'(d0); mn = TW'(lo); mx = TW'(hi); duty = TW'(du);
        enable = 1'b1;
        rst_n = 1'b1;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int rc, fc, lc, pl, tr, tf, tl;
        int rc2, fc2, lc2, pl2, tr2, tf2, tl2;
        int both;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 gh in reset", int'(gh), 0);
        chk("R1 gl in reset", int'(gl), 0);
        chk("R1 taps in reset", int'({trise, tfall, tglr}), 0);
        // R1: enable low keeps both gates off
        rst_n = 1'b1;
        per = 10'd20; dd = 14'd40; mn = 14'd16; mx = 14'd300; duty = 14'd100;
        both = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (gh || gl) both++;
        end
        chk("R1 gates active while disabled", both, 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            calc(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], rc, fc, lc, pl, tr, tf, tl);
            start_run(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
            observe(rc, fc, lc, pl, $sformatf("R3 R5 R6 R7 vec%0d p1", v));
            observe(rc, fc, lc, pl, $sformatf("R2 vec%0d p2", v));
            if (rc != pl) begin
                chk($sformatf("R4 vec%0d gh_rise_tap", v), int'(trise), tr);
                chk($sformatf("R4 vec%0d gh_fall_tap", v), int'(tfall), tf);
                chk($sformatf("R4 vec%0d gl_rise_tap", v), int'(tglr), tl);
            end
        end

        // R9: mid-period change only affects the next period
        calc(30, 40, 16, 1000, 100, rc, fc, lc, pl, tr, tf, tl);
        calc(30, 64, 16, 1000, 300, rc2, fc2, lc2, pl2, tr2, tf2, tl2);
        start_run(30, 40, 16, 1000, 100);
        hk_k = 5; hk_duty = 300; hk_dead = 64; hk_en = 1;
        observe(rc, fc, lc, pl, "R9 period with mid change");
        hk_k = -1;
        chk("R9 tap held through change", int'(tfall), tf);
        observe(rc2, fc2, lc2, pl2, "R9 next period uses new values");
        chk("R9 new fall tap", int'(tfall), tf2);

        // R10: disable mid-period completes the period then idles
        start_run(30, 40, 16, 1000, 100);
        hk_k = 3; hk_duty = 100; hk_dead = 40; hk_en = 0;
        observe(rc, fc, lc, pl, "R10 period completing after disable");
        hk_k = -1;
        observe(pl, pl, pl, pl, "R10 idle after disable");
        chk("R10 taps kept", int'({trise, tfall, tglr}), int'({FW'(tr), FW'(tf), FW'(tl)}));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule